// File: doc/BRIEF.md
# Local Interrupt Controller Timer

A programmable countdown timer that raises a vectored interrupt request toward a processor core. Software programs a control word holding an 8-bit vector, a mask bit and a mode field. It also programs a divider for the timer clock. It then either loads a start count or, in absolute mode, a target timestamp. The block runs in one of three modes. In single-shot mode it counts down once and signals. In repeating mode it reloads and keeps going. In absolute mode it compares a target against a free-running timestamp supplied at its input.

The request is a level that stays high, with the vector it was raised for, until the core acknowledges it. Changing between single-shot and repeating on the fly leaves the running count alone. A target timestamp that has already passed fires at once and then reads back as zero. Register access is a single-cycle write strobe with an address, and a combinational read of the same address.

Top module: `lvt_timer`

## Requirements
- R1: Writing the start-count register (address 1) outside absolute mode loads the running count (address 2) with the written value immediately after that write edge; with divide-by-D the request rises after exactly N*D further clock edges for a start count N.
- R2: The divider register (address 3) keeps bits 3, 1 and 0 of the written value as code c = {b3,b1,b0}; c = 7 (for example the value 0xB) divides by 1, any other c divides by 2^(c+1); it reads back with bits 3, 1 and 0 in place and all other bits zero.
- R3: In single-shot mode (control bits 18:17 = 00) the count reaches zero, raises exactly one request, and then stays at zero.
- R4: In repeating mode (control bits 18:17 = 01) the count reloads from the start count on the edge where it reaches zero, raises a request there, and keeps counting.
- R5: Writing the control word to change between single-shot and repeating neither reloads nor resets the running count, which keeps decrementing, and the start count keeps its value.
- R6: With the count at zero in single-shot mode, a change to repeating mode leaves the count at zero, with no reload and no request.
- R7: In absolute mode (control bits 18:17 = 10) a target (address 4) at or below the timestamp input raises the request on the next clock edge, and the target register then reads zero.
- R8: In absolute mode a future target raises the request on the edge after the timestamp input reaches it, and until then it reads back its written value.
- R9: With the mask bit (control bit 16) set, no request is raised, but counting and the clearing of a fired target go on as normal.
- R10: Writing a start count of zero stops the timer at zero without raising a request.
- R11: In absolute mode, writes to the start count are ignored and both the start-count and running-count registers read zero; outside absolute mode the target register reads zero and ignores writes.
- R12: The request stays high until the acknowledge input is sampled high on a clock edge, and the vector output carries control bits 7:0 as they stood when it fired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; also the timer input clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i (combinational) |
| tsc_i | input | DW | Free-running timestamp |
| irq_ack_i | input | 1 | Acknowledge, clears the request |
| irq_o | output | 1 | Interrupt request level |
| irq_vec_o | output | VEC_W | Vector of the pending request |

## Verification
A start count written on edge k is readable as the running count just after edge k, and the request is due after edge k+N*D. The control-word write edge itself still decrements, so a mode change leaves one count fewer than the cycles elapsed before it. An acknowledge takes one edge, and in repeating mode that edge is part of the next period. A target due now fires one edge after the write or after the timestamp change. The bench drives inputs on the falling edge, samples there, and counts falling edges between a write and the request, so every expected cycle count follows from N, D and these fixed offsets.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_DEADLINE = 2'b10
    } lvt_mode_e;

    localparam int ADDR_W     = 3;
    localparam int DIV_CODE_W = 3;
    localparam int MASK_BIT   = 16;
    localparam int MODE_LO    = 17;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_START = 3'd1;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd2;
    localparam logic [ADDR_W-1:0] A_DIV   = 3'd3;
    localparam logic [ADDR_W-1:0] A_DLINE = 3'd4;

    typedef struct packed {
        logic [7:0] vec;
        logic       mask;
        lvt_mode_e  mode;
    } lvt_cfg_t;

    function automatic lvt_mode_e mode_decode(input logic [1:0] f);
        case (f)
            2'b01:   return MODE_PERIODIC;
            2'b10:   return MODE_DEADLINE;
            default: return MODE_ONESHOT;
        endcase
    endfunction

    function automatic logic [DIV_CODE_W-1:0] div_pack(input logic [3:0] raw);
        return {raw[3], raw[1:0]};
    endfunction

    function automatic logic [3:0] div_unpack(input logic [DIV_CODE_W-1:0] c);
        return {c[2], 1'b0, c[1:0]};
    endfunction

endpackage

// File: rtl/lvt_prescaler.sv
module lvt_prescaler
    import lvt_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  restart_i,
    input  logic [DIV_CODE_W-1:0] code_i,
    output logic                  tick_o
);
    localparam int PW = (1 << DIV_CODE_W) - 1;

    logic [PW-1:0]         cnt_q;
    logic [PW-1:0]         limit;
    logic [DIV_CODE_W-1:0] sh;

    always_comb begin
        sh = DIV_CODE_W'(PW - 1) - code_i;
        if (code_i == '1) limit = '0;
        else              limit = {PW{1'b1}} >> sh;
    end

    assign tick_o = (cnt_q == limit);

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) cnt_q <= '0;
        else if (tick_o)        cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/lvt_countdown.sv
module lvt_countdown
    import lvt_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          tick_i,
    input  lvt_mode_e     mode_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          clear_i,
    output logic [CW-1:0] cur_o,
    output logic [CW-1:0] init_o,
    output logic          fire_o
);
    logic [CW-1:0] cur_q, init_q;
    logic          run;

    assign run    = tick_i && (cur_q != '0) && (mode_i != MODE_DEADLINE);
    assign fire_o = run && (cur_q == CW'(1)) && !load_i && !clear_i;

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            cur_q  <= '0;
            init_q <= '0;
        end else if (load_i) begin
            cur_q  <= load_val_i;
            init_q <= load_val_i;
        end else if (run) begin
            if (cur_q == CW'(1))
                cur_q <= (mode_i == MODE_PERIODIC) ? init_q : '0;
            else
                cur_q <= cur_q - 1'b1;
        end
    end

    assign cur_o  = cur_q;
    assign init_o = init_q;
endmodule

// File: rtl/lvt_deadline.sv
module lvt_deadline #(
    parameter int DW = 32
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          active_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wval_i,
    input  logic [DW-1:0] tsc_i,
    output logic [DW-1:0] dl_o,
    output logic          fire_o
);
    logic [DW-1:0] dl_q;

    assign fire_o = active_i && (dl_q != '0) && (tsc_i >= dl_q) && !wr_i;

    always_ff @(posedge clk_i) begin
        if (rst_i || !active_i) dl_q <= '0;
        else if (wr_i)          dl_q <= wval_i;
        else if (fire_o)        dl_q <= '0;
    end

    assign dl_o = dl_q;
endmodule

// File: rtl/lvt_irq_latch.sv
module lvt_irq_latch #(
    parameter int VEC_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             set_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic             ack_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            irq_o <= 1'b0;
            vec_o <= '0;
        end else if (set_i) begin
            irq_o <= 1'b1;
            vec_o <= vec_i;
        end else if (ack_i) begin
            irq_o <= 1'b0;
        end
    end
endmodule

// File: rtl/lvt_timer.sv
module lvt_timer
    import lvt_pkg::*;
#(
    parameter int DW    = 32,
    parameter int VEC_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    input  logic [DW-1:0]     tsc_i,
    input  logic              irq_ack_i,
    output logic              irq_o,
    output logic [VEC_W-1:0]  irq_vec_o
);
    lvt_cfg_t              cfg_q;
    logic [DIV_CODE_W-1:0] div_q;
    lvt_mode_e             new_mode;
    logic wr_ctrl, wr_start, wr_div, wr_dline;
    logic cd_load, cd_clear, tick, cd_fire, dl_fire, dl_active;
    logic [DW-1:0] cur_cnt, init_cnt, dl_val;

    assign wr_ctrl  = wr_en_i && (addr_i == A_CTRL);
    assign wr_start = wr_en_i && (addr_i == A_START);
    assign wr_div   = wr_en_i && (addr_i == A_DIV);
    assign wr_dline = wr_en_i && (addr_i == A_DLINE);

    assign new_mode  = mode_decode(wdata_i[MODE_LO +: 2]);
    assign dl_active = (cfg_q.mode == MODE_DEADLINE);
    assign cd_clear  = wr_ctrl && (new_mode == MODE_DEADLINE);
    assign cd_load   = wr_start && !dl_active;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= '{vec: '0, mask: 1'b0, mode: MODE_ONESHOT};
            div_q <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg_q.vec  <= wdata_i[7:0];
                cfg_q.mask <= wdata_i[MASK_BIT];
                cfg_q.mode <= new_mode;
            end
            if (wr_div) div_q <= div_pack(wdata_i[3:0]);
        end
    end

    lvt_prescaler u_presc (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (wr_start || wr_div),
        .code_i    (div_q),
        .tick_o    (tick)
    );

    lvt_countdown #(.CW(DW)) u_count (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_i     (tick),
        .mode_i     (cfg_q.mode),
        .load_i     (cd_load),
        .load_val_i (wdata_i),
        .clear_i    (cd_clear),
        .cur_o      (cur_cnt),
        .init_o     (init_cnt),
        .fire_o     (cd_fire)
    );

    lvt_deadline #(.DW(DW)) u_dline (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .active_i (dl_active),
        .wr_i     (wr_dline),
        .wval_i   (wdata_i),
        .tsc_i    (tsc_i),
        .dl_o     (dl_val),
        .fire_o   (dl_fire)
    );

    lvt_irq_latch #(.VEC_W(VEC_W)) u_irq (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .set_i ((cd_fire || dl_fire) && !cfg_q.mask),
        .vec_i (VEC_W'(cfg_q.vec)),
        .ack_i (irq_ack_i),
        .irq_o (irq_o),
        .vec_o (irq_vec_o)
    );

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CTRL: begin
                rdata_o[7:0]          = cfg_q.vec;
                rdata_o[MASK_BIT]     = cfg_q.mask;
                rdata_o[MODE_LO +: 2] = cfg_q.mode;
            end
            A_START: rdata_o = init_cnt;
            A_COUNT: rdata_o = cur_cnt;
            A_DIV:   rdata_o[3:0] = div_unpack(div_q);
            A_DLINE: rdata_o = dl_val;
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/lvt_timer_chk.sv
module lvt_timer_chk
    import lvt_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk_i,
    input logic          rst_i,
    input logic          irq_o,
    input logic          irq_ack_i,
    input logic          mask,
    input lvt_mode_e     mode,
    input logic [DW-1:0] cur,
    input logic [DW-1:0] init,
    input logic [DW-1:0] dline,
    input logic          dl_fire,
    input logic          dl_wr,
    input logic          tick,
    input logic          cd_load,
    input logic          cd_clear
);
    AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_o && !irq_ack_i) |=> irq_o); // R12

    AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (mask && !irq_o) |=> !irq_o); // R9

    AST_ONESHOT_STAY: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode == MODE_ONESHOT && cur == '0 && !cd_load) |=> (cur == '0)); // R3

    AST_PERIODIC_RELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode == MODE_PERIODIC && cur == DW'(1) && tick && !cd_load && !cd_clear)
        |=> (cur == init && init != '0)); // R4

    AST_DLINE_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        (dl_fire && !dl_wr) |=> (dline == '0)); // R7

    AST_DLINE_ZERO_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode == MODE_DEADLINE) |-> (cur == '0 && init == '0)); // R11
endmodule

bind lvt_timer lvt_timer_chk #(.DW(DW)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .irq_o     (irq_o),
    .irq_ack_i (irq_ack_i),
    .mask      (cfg_q.mask),
    .mode      (cfg_q.mode),
    .cur       (cur_cnt),
    .init      (init_cnt),
    .dline     (dl_val),
    .dl_fire   (dl_fire),
    .dl_wr     (wr_dline),
    .tick      (tick),
    .cd_load   (cd_load),
    .cd_clear  (cd_clear)
);

// File: tb/lvt_timer_test.sv
module lvt_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] tsc = '0;
    logic        ack = 1'b0;
    logic        irq;
    logic [7:0]  irq_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [2:0] CTRL = 3'd0, START = 3'd1, COUNT = 3'd2, DIVR = 3'd3, DLINE = 3'd4;

    always #4 clk = ~clk;

    lvt_timer uut (
        .clk_i     (clk),
        .rst_i     (rst),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .tsc_i     (tsc),
        .irq_ack_i (ack),
        .irq_o     (irq),
        .irq_vec_o (irq_vec)
    );

    function automatic logic [31:0] ctrl_word(input logic [7:0] v, input logic m, input logic [1:0] md);
        return (32'(md) << 17) | (32'(m) << 16) | 32'(v);
    endfunction

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input int maxc, output int c);
        c = 0;
        while (!irq && c < maxc) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic ack_pulse;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic quiesce;
        wr(START, 32'd0);
        ack_pulse();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] r;
        int c;
        step(3);
        rst = 1'b0;

        // reset state
        rd(CTRL, r);  check("R12 ctrl after reset", r, 32'h0);
        rd(COUNT, r); check("R1 count after reset", r, 32'h0);
        rd(DIVR, r);  check("R2 divider after reset", r, 32'h0);
        check("R12 irq after reset", 32'(irq), 32'h0);

        // divider readback
        wr(DIVR, 32'hFFFF_FFFB);
        rd(DIVR, r); check("R2 divider readback 0xB", r, 32'hB);

        // sweep of all divider codes and several start counts
        for (int v = 0; v < 8; v++) begin
            for (int k = 0; k < 4; k++) begin
                int n, d;
                logic [2:0] cv;
                n  = (k == 3) ? 5 : k + 1;
                cv = 3'(v);
                d  = (v == 7) ? 1 : (1 << (v + 1));
                wr(DIVR, {28'h0, cv[2], 1'b0, cv[1:0]});
                wr(CTRL, ctrl_word(8'h40 + 8'(v), 1'b0, 2'b00));
                wr(START, 32'(n));
                rd(COUNT, r); check("R1 count loaded", r, 32'(n));
                wait_irq(1000, c);
                check("R2 request delay N*D", 32'(c), 32'(n * d));
                check("R12 vector", 32'(irq_vec), 32'h40 + 32'(v));
                rd(COUNT, r); check("R3 count at zero", r, 32'h0);
                ack_pulse();
                step(n * d + 3);
                check("R3 single request only", 32'(irq), 32'h0);
            end
        end

        // running count readback at divide-by-1
        wr(DIVR, 32'hB);
        wr(START, 32'd10);
        step(4);
        rd(COUNT, r); check("R1 count decrements", r, 32'd6);

        // zero start count stops the timer
        wr(START, 32'd0);
        rd(COUNT, r); check("R10 count stopped", r, 32'h0);
        step(15);
        check("R10 no request", 32'(irq), 32'h0);

        // repeating mode
        wr(CTRL, ctrl_word(8'h21, 1'b0, 2'b01));
        wr(START, 32'd4);
        wait_irq(100, c); check("R4 first period", 32'(c), 32'd4);
        rd(COUNT, r); check("R4 reload on zero", r, 32'd4);
        ack_pulse();
        wait_irq(100, c); check("R4 second period", 32'(c), 32'd3);
        rd(START, r); check("R4 start count kept", r, 32'd4);

        // mode change keeps the running count
        quiesce();
        wr(CTRL, ctrl_word(8'h22, 1'b0, 2'b00));
        wr(START, 32'd20);
        step(5);
        wr(CTRL, ctrl_word(8'h22, 1'b0, 2'b01));
        rd(COUNT, r); check("R5 count kept on mode change", r, 32'd14);
        rd(START, r); check("R5 start kept on mode change", r, 32'd20);
        wait_irq(100, c); check("R5 fire from kept count", 32'(c), 32'd14);
        ack_pulse();
        wait_irq(100, c); check("R5 period after reload", 32'(c), 32'd19);
        ack_pulse();
        wr(CTRL, ctrl_word(8'h22, 1'b0, 2'b00));
        rd(COUNT, r); check("R5 count kept back to single-shot", r, 32'd18);
        wait_irq(100, c); check("R5 single-shot finishes", 32'(c), 32'd18);
        ack_pulse();
        step(30);
        check("R3 stays quiet", 32'(irq), 32'h0);

        // zero count in single-shot then repeating
        quiesce();
        wr(START, 32'd3);
        wait_irq(100, c);
        ack_pulse();
        wr(CTRL, ctrl_word(8'h22, 1'b0, 2'b01));
        step(10);
        check("R6 no request", 32'(irq), 32'h0);
        rd(COUNT, r); check("R6 count stays zero", r, 32'h0);
        rd(START, r); check("R6 start kept", r, 32'd3);

        // mask
        quiesce();
        wr(CTRL, ctrl_word(8'h23, 1'b1, 2'b00));
        wr(START, 32'd6);
        step(3);
        rd(COUNT, r); check("R9 counting while masked", r, 32'd3);
        step(3);
        rd(COUNT, r); check("R9 reached zero masked", r, 32'h0);
        step(10);
        check("R9 request suppressed", 32'(irq), 32'h0);

        // absolute mode, past target
        quiesce();
        wr(CTRL, ctrl_word(8'h5A, 1'b0, 2'b10));
        tsc = 32'd1000;
        rd(START, r); check("R11 start reads zero", r, 32'h0);
        wr(DLINE, 32'd900);
        check("R7 not before next edge", 32'(irq), 32'h0);
        step(1);
        check("R7 past target fires", 32'(irq), 32'h1);
        check("R12 vector absolute", 32'(irq_vec), 32'h5A);
        rd(DLINE, r); check("R7 target cleared", r, 32'h0);
        step(8);
        check("R12 held without ack", 32'(irq), 32'h1);
        ack_pulse();
        check("R12 cleared by ack", 32'(irq), 32'h0);
        wr(DLINE, 32'd1000);
        step(1);
        check("R7 equal target fires", 32'(irq), 32'h1);
        ack_pulse();

        // future target
        wr(DLINE, 32'd1005);
        step(5);
        check("R8 not yet", 32'(irq), 32'h0);
        rd(DLINE, r); check("R8 target readback", r, 32'd1005);
        tsc = 32'd1005;
        step(1);
        check("R8 fires on reach", 32'(irq), 32'h1);
        rd(DLINE, r); check("R8 target cleared", r, 32'h0);
        ack_pulse();

        // start count ignored in absolute mode
        wr(START, 32'd50);
        rd(START, r); check("R11 start ignored", r, 32'h0);
        rd(COUNT, r); check("R11 count reads zero", r, 32'h0);
        step(60);
        check("R11 no request", 32'(irq), 32'h0);

        // masked absolute target still clears
        wr(CTRL, ctrl_word(8'h5B, 1'b1, 2'b10));
        wr(DLINE, 32'd10);
        step(2);
        check("R9 masked target silent", 32'(irq), 32'h0);
        rd(DLINE, r); check("R9 masked target cleared", r, 32'h0);

        // target ignored outside absolute mode
        wr(CTRL, ctrl_word(8'h5B, 1'b0, 2'b00));
        wr(DLINE, 32'd2000);
        rd(DLINE, r); check("R11 target ignored outside mode", r, 32'h0);

        summary();
    end
endmodule